// File: doc/BRIEF.md
# Configurable Pad Cell Group

This block models a group of general-purpose pad cells that sit between the core logic and the package pins. Each cell is set up by its own configuration field as a plain input, an input captured on an I/O clock edge, an input held by a level-sensitive latch, a dedicated output, or a bidirectional pin whose driver is switched. The pad itself is modelled as three signals: the value coming in from the pin, the value sent to the pin and the driver enable.

Every cell picks one of several I/O clock lines to time its capture register and its latch, and may invert the value it sends to the pin. All bidirectional cells in the group obey one shared output enable, while dedicated output cells drive at all times. The core reads each cell's input value on a single output bit and supplies each cell's output value on a single input bit.

An active-low reset clears the capture register and the latch of every cell at once. The release of that reset is synchronised separately to each I/O clock line before it reaches the cells.

Top module: `pio_group`

## Requirements
- R1: With mode code 3'b000 (plain input) the cell's core input bit follows the pad input with no clock involved, and its driver enable is 0.
- R2: With mode code 3'b001 (registered input) the core input bit shows the pad input as sampled at the latest rising edge of the selected I/O clock, and it holds between those edges.
- R3: With mode code 3'b010 (latched input) the core input bit follows the pad input while the selected I/O clock is high and holds the last value while that clock is low.
- R4: With mode code 3'b011 (output) the driver enable is 1 whatever the shared enable is, and the core input bit reads 0.
- R5: With mode code 3'b100 (bidirectional) the driver enable equals the shared group enable, and the core input bit follows the pad input so the driven value can be read back.
- R6: The pad output bit equals the core output bit when the cell's invert bit is 0 and its complement when the invert bit is 1, in every mode.
- R7: A clock-select bit of 0 times the cell from I/O clock line 0 and a value of 1 times it from line 1; cells in one group may use different lines.
- R8: While the reset input is low the capture register and the latch of every cell read 0 at once; after release each cell resumes capture once two edges of its own I/O clock have passed.
- R9: Mode codes 3'b101, 3'b110 and 3'b111 act as plain input: the core input bit follows the pad input and the driver enable is 0.
- R10: Cells are configured independently: within one group, output cells drive while bidirectional cells follow the shared enable, and an invert bit affects only its own cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released per I/O clock line |
| io_clk | input | N_CLKS | I/O clock lines available to every cell |
| grp_oe | input | 1 | Output enable shared by all bidirectional cells |
| cfg_mode | input | 3*N_CELLS | Mode code of cell i in bits [3i+2:3i] |
| cfg_inv | input | N_CELLS | Per-cell output invert bit |
| cfg_clksel | input | SEL_W*N_CELLS | Per-cell I/O clock line select, cell i in bits [SEL_W*i +: SEL_W] |
| core_out | input | N_CELLS | Value the core sends to each pin |
| core_in | output | N_CELLS | Value each cell hands to the core |
| pad_i | input | N_CELLS | Value present on each pin |
| pad_o | output | N_CELLS | Value each cell places on its pin |
| pad_oe | output | N_CELLS | Driver enable of each pin |

## Verification
The bench builds the group with its defaults, sixteen cells and two I/O clock lines, the second running at half the rate of the first. Two lines at different rates make it possible to show that a registered cell on the slow line keeps its old value across a fast-line edge while cells on the fast line in the same group already show the new value. Sixteen cells leave room to place output, bidirectional and reserved-code cells side by side so the shared enable and the per-cell invert bits are seen acting on their own cells only.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int PIO_MODE_W = 3;

  typedef enum logic [PIO_MODE_W-1:0] {
    PIO_IN_COMB  = 3'b000,
    PIO_IN_REG   = 3'b001,
    PIO_IN_LATCH = 3'b010,
    PIO_OUT      = 3'b011,
    PIO_BIDIR    = 3'b100
  } pio_mode_e;

  typedef enum logic [1:0] {
    SRC_PAD   = 2'd0,
    SRC_REG   = 2'd1,
    SRC_LATCH = 2'd2,
    SRC_ZERO  = 2'd3
  } pio_src_e;

endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/pio_capture.sv
module pio_capture (
  input  logic cap_clk,
  input  logic cap_rst_n,
  input  logic reg_en,
  input  logic pad_i,
  output logic reg_q,
  output logic lat_q
);

  logic reg_d;

  // next-state of the edge-triggered capture, enable written out
  always_comb begin
    reg_d = reg_en ? pad_i : reg_q;
  end

  always_ff @(posedge cap_clk or negedge cap_rst_n) begin
    if (!cap_rst_n) reg_q <= 1'b0;
    else            reg_q <= reg_d;
  end

  // level-sensitive capture: open while the selected clock is high
  always_latch begin
    if (!cap_rst_n)   lat_q <= 1'b0;
    else if (cap_clk) lat_q <= pad_i;
  end

endmodule

// File: rtl/pio_cell.sv
module pio_cell
  import pio_pkg::*;
#(
  parameter int N_CLKS = 2,
  parameter int SEL_W  = 1
) (
  input  logic [N_CLKS-1:0]     io_clk,
  input  logic [N_CLKS-1:0]     rst_sync_n,
  input  logic                  grp_oe,
  input  logic [PIO_MODE_W-1:0] mode,
  input  logic                  inv,
  input  logic [SEL_W-1:0]      clk_sel,
  input  logic                  core_out,
  input  logic                  pad_i,
  output logic                  core_in,
  output logic                  pad_o,
  output logic                  pad_oe
);

  logic     cap_clk;
  logic     cap_rst_n;
  logic     reg_en;
  logic     reg_q;
  logic     lat_q;
  logic     drv_en;
  pio_src_e src;

  assign cap_clk   = io_clk[clk_sel];
  assign cap_rst_n = rst_sync_n[clk_sel];

  always_comb begin
    reg_en = 1'b0;
    drv_en = 1'b0;
    src    = SRC_PAD;
    case (mode)
      PIO_IN_REG: begin
        reg_en = 1'b1;
        src    = SRC_REG;
      end
      PIO_IN_LATCH: src = SRC_LATCH;
      PIO_OUT: begin
        drv_en = 1'b1;
        src    = SRC_ZERO;
      end
      PIO_BIDIR: drv_en = grp_oe;
      default: begin
        reg_en = 1'b0;
        drv_en = 1'b0;
        src    = SRC_PAD;
      end
    endcase
  end

  pio_capture u_capture (
    .cap_clk   (cap_clk),
    .cap_rst_n (cap_rst_n),
    .reg_en    (reg_en),
    .pad_i     (pad_i),
    .reg_q     (reg_q),
    .lat_q     (lat_q)
  );

  always_comb begin
    case (src)
      SRC_REG:   core_in = reg_q;
      SRC_LATCH: core_in = lat_q;
      SRC_ZERO:  core_in = 1'b0;
      default:   core_in = pad_i;
    endcase
  end

  assign pad_o  = core_out ^ inv;
  assign pad_oe = drv_en;

endmodule

// File: rtl/pio_group.sv
module pio_group
  import pio_pkg::*;
#(
  parameter int N_CELLS    = 16,
  parameter int N_CLKS     = 2,
  parameter int RST_STAGES = 2,
  localparam int SEL_W     = (N_CLKS > 1) ? $clog2(N_CLKS) : 1
) (
  input  logic                          rst_n,
  input  logic [N_CLKS-1:0]             io_clk,
  input  logic                          grp_oe,
  input  logic [PIO_MODE_W*N_CELLS-1:0] cfg_mode,
  input  logic [N_CELLS-1:0]            cfg_inv,
  input  logic [SEL_W*N_CELLS-1:0]      cfg_clksel,
  input  logic [N_CELLS-1:0]            core_out,
  output logic [N_CELLS-1:0]            core_in,
  input  logic [N_CELLS-1:0]            pad_i,
  output logic [N_CELLS-1:0]            pad_o,
  output logic [N_CELLS-1:0]            pad_oe
);

  logic [N_CLKS-1:0] rst_sync_n;

  for (genvar k = 0; k < N_CLKS; k++) begin : g_rst
    pio_rst_sync #(.STAGES(RST_STAGES)) u_sync (
      .clk    (io_clk[k]),
      .arst_n (rst_n),
      .srst_n (rst_sync_n[k])
    );
  end

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    pio_cell #(.N_CLKS(N_CLKS), .SEL_W(SEL_W)) u_cell (
      .io_clk     (io_clk),
      .rst_sync_n (rst_sync_n),
      .grp_oe     (grp_oe),
      .mode       (cfg_mode[PIO_MODE_W*i +: PIO_MODE_W]),
      .inv        (cfg_inv[i]),
      .clk_sel    (cfg_clksel[SEL_W*i +: SEL_W]),
      .core_out   (core_out[i]),
      .pad_i      (pad_i[i]),
      .core_in    (core_in[i]),
      .pad_o      (pad_o[i]),
      .pad_oe     (pad_oe[i])
    );
  end

endmodule

// File: rtl/pio_group_chk.sv
module pio_group_chk
  import pio_pkg::*;
#(
  parameter int N_CELLS = 16,
  parameter int N_CLKS  = 2,
  parameter int SEL_W   = 1
) (
  input logic                          rst_n,
  input logic [N_CLKS-1:0]             io_clk,
  input logic                          grp_oe,
  input logic [PIO_MODE_W*N_CELLS-1:0] cfg_mode,
  input logic [N_CELLS-1:0]            cfg_inv,
  input logic [SEL_W*N_CELLS-1:0]      cfg_clksel,
  input logic [N_CELLS-1:0]            core_out,
  input logic [N_CELLS-1:0]            core_in,
  input logic [N_CELLS-1:0]            pad_i,
  input logic [N_CELLS-1:0]            pad_o,
  input logic [N_CELLS-1:0]            pad_oe
);

  // edges of line 0 since reset release, saturating once capture is live
  logic [2:0] settle_cnt;
  logic       settled;

  always_ff @(posedge io_clk[0] or negedge rst_n) begin
    if (!rst_n)                 settle_cnt <= '0;
    else if (settle_cnt != 3'd4) settle_cnt <= settle_cnt + 3'd1;
  end

  assign settled = (settle_cnt == 3'd4);

  for (genvar i = 0; i < N_CELLS; i++) begin : g_chk
    logic [PIO_MODE_W-1:0] m;
    logic [SEL_W-1:0]      s;
    assign m = cfg_mode[PIO_MODE_W*i +: PIO_MODE_W];
    assign s = cfg_clksel[SEL_W*i +: SEL_W];

    AST_OUT_ALWAYS_DRIVES: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
      (m == PIO_OUT) |-> pad_oe[i]); // R4
    AST_BIDIR_SHARED_OE: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
      (m == PIO_BIDIR) |-> (pad_oe[i] == grp_oe)); // R5
    AST_BIDIR_READBACK: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
      (m == PIO_BIDIR) |-> (core_in[i] == pad_i[i])); // R5
    AST_INPUT_NO_DRIVE: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
      ((m != PIO_OUT) && (m != PIO_BIDIR)) |-> !pad_oe[i]); // R1
    AST_OUTPUT_POLARITY: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
      1'b1 |-> (pad_o[i] == (core_out[i] ^ cfg_inv[i]))); // R6
    AST_REG_EDGE_SAMPLE: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
      (settled && (m == PIO_IN_REG) && ($past(m) == PIO_IN_REG) &&
       (s == '0) && ($past(s) == '0)) |-> (core_in[i] == $past(pad_i[i]))); // R2
    AST_LATCH_OPEN_HIGH: assert property (@(negedge io_clk[0]) disable iff (!rst_n)
      (settled && (m == PIO_IN_LATCH) && (s == '0)) |-> (core_in[i] == pad_i[i])); // R3
  end

endmodule

bind pio_group pio_group_chk #(
  .N_CELLS (N_CELLS),
  .N_CLKS  (N_CLKS),
  .SEL_W   (SEL_W)
) u_pio_group_chk (
  .rst_n      (rst_n),
  .io_clk     (io_clk),
  .grp_oe     (grp_oe),
  .cfg_mode   (cfg_mode),
  .cfg_inv    (cfg_inv),
  .cfg_clksel (cfg_clksel),
  .core_out   (core_out),
  .core_in    (core_in),
  .pad_i      (pad_i),
  .pad_o      (pad_o),
  .pad_oe     (pad_oe)
);

// File: tb/pio_group_bench.sv
module pio_group_bench;

  localparam int N  = 16;
  localparam int NC = 2;

  logic          clk0 = 1'b0;
  logic          clk1 = 1'b0;
  logic [NC-1:0] io_clk;
  logic          rst_n;
  logic          grp_oe;
  logic [3*N-1:0] cfg_mode;
  logic [N-1:0]  cfg_inv;
  logic [N-1:0]  cfg_clksel;
  logic [N-1:0]  core_out;
  logic [N-1:0]  core_in;
  logic [N-1:0]  pad_i;
  logic [N-1:0]  pad_o;
  logic [N-1:0]  pad_oe;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk0 = ~clk0;
  always @(posedge clk0) clk1 <= ~clk1;
  assign io_clk = {clk1, clk0};

  pio_group #(.N_CELLS(N), .N_CLKS(NC)) u_pio_group (
    .rst_n      (rst_n),
    .io_clk     (io_clk),
    .grp_oe     (grp_oe),
    .cfg_mode   (cfg_mode),
    .cfg_inv    (cfg_inv),
    .cfg_clksel (cfg_clksel),
    .core_out   (core_out),
    .core_in    (core_in),
    .pad_i      (pad_i),
    .pad_o      (pad_o),
    .pad_oe     (pad_oe)
  );

  function automatic logic [3*N-1:0] all_mode(input logic [2:0] m);
    logic [3*N-1:0] v;
    for (int i = 0; i < N; i++) v[3*i +: 3] = m;
    return v;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n      = 1'b0;
    grp_oe     = 1'b0;
    cfg_mode   = all_mode(3'b001);
    cfg_inv    = '0;
    cfg_clksel = '0;
    core_out   = '0;
    pad_i      = '1;
    repeat (3) @(negedge clk0);
    chk("R8", "core_in held in reset", core_in, '0);
    chk("R8", "pad_oe in reset", pad_oe, '0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk0);
    chk("R2", "capture after release", core_in, '1);
    #3 rst_n = 1'b0;
    #1 chk("R8", "async clear mid-run", core_in, '0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk0);
    chk("R8", "capture resumes", core_in, '1);
  endtask

  task automatic t_comb;
    @(negedge clk0);
    cfg_mode = all_mode(3'b000);
    pad_i    = 16'hA5C3;
    #1 chk("R1", "plain input follows pad", core_in, 16'hA5C3);
    chk("R1", "plain input no drive", pad_oe, '0);
    pad_i = 16'h3C5A;
    #1 chk("R1", "plain input second pattern", core_in, 16'h3C5A);
  endtask

  task automatic t_reg;
    @(negedge clk0);
    cfg_mode   = all_mode(3'b001);
    cfg_clksel = '0;
    pad_i      = 16'h1234;
    @(negedge clk0);
    chk("R2", "sampled on edge", core_in, 16'h1234);
    pad_i = 16'hFEDC;
    #5 chk("R2", "holds between edges", core_in, 16'h1234);
    @(negedge clk0);
    chk("R2", "next edge sample", core_in, 16'hFEDC);
  endtask

  task automatic t_clksel;
    @(negedge clk0);
    cfg_clksel = '1;
    pad_i      = 16'h0F0F;
    repeat (4) @(negedge clk0);
    @(posedge clk1);
    @(negedge clk0);
    pad_i = 16'hF0F0;
    @(negedge clk0);
    chk("R7", "line 1 ignores line 0 edge", core_in, 16'h0F0F);
    @(negedge clk0);
    chk("R7", "line 1 edge captures", core_in, 16'hF0F0);
    @(posedge clk1);
    @(negedge clk0);
    cfg_clksel = 16'h00FF;
    pad_i      = 16'hFFFF;
    @(negedge clk0);
    chk("R7", "mixed lines after fast edge", core_in, 16'hFFF0);
    @(negedge clk0);
    chk("R7", "mixed lines after slow edge", core_in, 16'hFFFF);
  endtask

  task automatic t_latch;
    @(negedge clk0);
    cfg_mode   = all_mode(3'b010);
    cfg_clksel = '0;
    #2 pad_i = 16'h5555;
    #1 chk("R3", "closed while low", core_in, 16'hFFFF);
    @(posedge clk0);
    #1 chk("R3", "open while high", core_in, 16'h5555);
    #2 pad_i = 16'hAAAA;
    #1 chk("R3", "tracks while high", core_in, 16'hAAAA);
    @(negedge clk0);
    #2 pad_i = 16'h0001;
    #1 chk("R3", "holds after fall", core_in, 16'hAAAA);
  endtask

  task automatic t_out;
    @(negedge clk0);
    cfg_mode = all_mode(3'b011);
    grp_oe   = 1'b0;
    cfg_inv  = '0;
    core_out = 16'hC3A5;
    #1 chk("R4", "output drives without enable", pad_oe, '1);
    chk("R4", "output mode core_in", core_in, '0);
    chk("R6", "true polarity", pad_o, 16'hC3A5);
    cfg_inv = '1;
    #1 chk("R6", "inverted polarity", pad_o, 16'h3C5A);
    cfg_inv = 16'h00FF;
    #1 chk("R6", "mixed polarity", pad_o, 16'hC35A);
    cfg_inv = '0;
  endtask

  task automatic t_bidir;
    @(negedge clk0);
    cfg_mode = all_mode(3'b100);
    grp_oe   = 1'b0;
    #1 chk("R5", "bidir off with enable low", pad_oe, '0);
    grp_oe = 1'b1;
    #1 chk("R5", "bidir on with enable high", pad_oe, '1);
    pad_i = 16'h6789;
    #1 chk("R5", "bidir readback", core_in, 16'h6789);
  endtask

  task automatic t_mixed;
    @(negedge clk0);
    for (int i = 0; i < N; i++) cfg_mode[3*i +: 3] = (i % 2 == 0) ? 3'b011 : 3'b100;
    grp_oe   = 1'b0;
    core_out = 16'h0F0F;
    cfg_inv  = 16'h0008;
    #1 chk("R10", "out cells drive, bidir off", pad_oe, 16'h5555);
    chk("R10", "invert on one cell only", pad_o, 16'h0F07);
    grp_oe = 1'b1;
    #1 chk("R10", "shared enable reaches bidir", pad_oe, 16'hFFFF);
    cfg_inv = '0;
  endtask

  task automatic t_reserved;
    @(negedge clk0);
    for (int i = 0; i < N; i++) cfg_mode[3*i +: 3] = 3'(5 + (i % 3));
    grp_oe = 1'b1;
    pad_i  = 16'hBEEF;
    #1 chk("R9", "reserved codes no drive", pad_oe, '0);
    chk("R9", "reserved codes read pad", core_in, 16'hBEEF);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_comb();
        t_reg();
        t_clksel();
        t_latch();
        t_out();
        t_bidir();
        t_mixed();
        t_reserved();
      end
      begin
        #4000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule